// File: doc/BRIEF.md
# Variable Serial Clock Tick Generator

This block produces the half-period tick enable that a serial-interface master uses to build its shift clock from the system clock. A 32-bit configuration word carries two 16-bit half-period counts: the primary count in bits 15:0 and the alternate count in bits 31:16. In fixed mode every half-period of the serial clock lasts the primary count plus one system clock. In variable mode a 32-bit pattern selects a count for each half-period slot. Slot 0 uses pattern bit 0, slot 1 uses bit 1, and so on. A 0 selects the primary count and a 1 selects the alternate count. Thirty-two slots cover the sixteen clock cycles of a 16-bit word, so the serial clock rate can change partway through a word.

The shift engine holds `run` high while it is transferring. It pulses `wordStart` in the first cycle of each word. At that pulse the block captures the counts, the pattern and the mode. It then restarts at slot 0 with the clock level low. From there it emits one `halfTick` pulse each time a half-period ends. It also reports the slot in progress and the clock level it is tracking. Variable clocking is meant for master transfers of 16-bit words only. Programming the word length and selecting master mode belong to the surrounding logic.

Top module: `spi_varclk_gen`

## Requirements
- R1: After reset, `halfTick` is 0, `sclkLevel` is 0 and `slotIdx` is 0.
- R2: While `run` is low, no `halfTick` appears and the state is held idle. From the cycle after `run` is low, `slotIdx` is 0 and `sclkLevel` is 0. If `run` is high but no `wordStart` has been seen since `run` last went high, no `halfTick` appears.
- R3: When the captured variable-mode bit is 0, every half-period lasts (primary count + 1) system clocks and the pattern has no effect.
- R4: When the captured variable-mode bit is 1, slot i lasts (primary count + 1) clocks if pattern bit i is 0 and (alternate count + 1) clocks if pattern bit i is 1.
- R5: A `wordStart` cycle with `run` high produces no `halfTick`. From the next cycle, `slotIdx` is 0 and `sclkLevel` is 0. The first `halfTick` comes (count of slot 0 + 1) cycles after the `wordStart` cycle, even if a word was already in progress.
- R6: During the cycle of a `halfTick`, `sclkLevel` keeps the level of the half-period that is ending, and it inverts in the next cycle. Between ticks of a running word it does not change.
- R7: `slotIdx` gives the number of the slot that is ending during a `halfTick`. It advances by one after each tick and wraps from 31 to 0, and slot 32 uses pattern bit 0 again.
- R8: The counts, the pattern and the mode bit are taken only in the `wordStart` cycle. Changing those inputs during a word has no effect on that word.
- R9: The primary count is read from `cfgClkDiv[15:0]` and the alternate count from `cfgClkDiv[31:16]`.
- R10: A count of 0 gives a half-period of one system clock, so a tick can occur in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| run | input | 1 | Shift engine is transferring |
| wordStart | input | 1 | First cycle of a word; captures the configuration and restarts |
| cfgVarEn | input | 1 | 1 selects variable mode, 0 selects fixed mode |
| cfgClkDiv | input | 32 | [15:0] primary half-period count, [31:16] alternate count |
| cfgPattern | input | 32 | Per-slot count select, bit i for slot i |
| halfTick | output | 1 | One-cycle pulse at the end of each half-period |
| sclkLevel | output | 1 | Tracked serial clock level, low at word start |
| slotIdx | output | 5 | Half-period slot in progress |

## Verification
A wrong count or a wrong pattern lookup inside the block moves a `halfTick` by one or more cycles. A wrong slot index or level register shows up as a `slotIdx` or `sclkLevel` mismatch in the same tick cycle. Each tick is therefore compared with the exact cycle number, slot and level computed for it. An extra tick is caught in the cycle it appears. A lost tick is caught when the word ends. Capture is tested by scrambling the configuration inputs one cycle after every word starts. A stale or live-read shadow register therefore moves the very first later tick.

// File: rtl/spi_varclk_pkg.sv
package spi_varclk_pkg;

  // Strobes from the control FSM to the datapath, one cycle each.
  typedef struct packed {
    logic clear;    // run is low: drop to the idle state
    logic load;     // word start: capture the configuration and restart
    logic count;    // running, slot not yet complete: bump the counter
    logic advance;  // running, slot complete: tick, next slot, toggle level
  } vclkStrobes_t;

  typedef enum logic {
    VCLK_IDLE = 1'b0,
    VCLK_RUN  = 1'b1
  } vclkState_t;

endpackage

// File: rtl/spi_varclk_ctrl.sv
module spi_varclk_ctrl
  import spi_varclk_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         run,
  input  logic         wordStart,
  input  logic         slotDone,
  output vclkStrobes_t strb
);

  vclkState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    if (!run)
      stateD = VCLK_IDLE;
    else if (wordStart)
      stateD = VCLK_RUN;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      stateQ <= VCLK_IDLE;
    else
      stateQ <= stateD;
  end

  logic armed;
  assign armed = run && !wordStart && (stateQ == VCLK_RUN);

  always_comb begin
    strb         = '0;
    strb.clear   = !run;
    strb.load    = run && wordStart;
    strb.count   = armed && !slotDone;
    strb.advance = armed && slotDone;
  end

endmodule

// File: rtl/spi_varclk_dp.sv
module spi_varclk_dp
  import spi_varclk_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int PAT_W      = 32,
  parameter bit ENABLE_VAR = 1'b1,
  localparam int IDX_W     = $clog2(PAT_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  vclkStrobes_t       strb,
  input  logic               cfgVarEn,
  input  logic [2*DIV_W-1:0] cfgClkDiv,
  input  logic [PAT_W-1:0]   cfgPattern,
  output logic               slotDone,
  output logic               halfTick,
  output logic               sclkLevel,
  output logic [IDX_W-1:0]   slotIdx
);

  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(PAT_W - 1);

  // Configuration captured at word start.
  logic [DIV_W-1:0] divPriQ, divAltQ;
  logic [PAT_W-1:0] patQ;
  logic             varQ;

  // Running state.
  logic [DIV_W-1:0] cntQ;
  logic [IDX_W-1:0] idxQ;
  logic             levelQ;

  logic [DIV_W-1:0] curDiv;

  generate
    if (ENABLE_VAR) begin : g_var
      logic useAlt;
      assign useAlt = varQ && patQ[idxQ];
      assign curDiv = useAlt ? divAltQ : divPriQ;
    end else begin : g_fixed
      logic unusedCfg;
      assign unusedCfg = varQ ^ (^patQ) ^ (^divAltQ);
      assign curDiv    = divPriQ;
    end
  endgenerate

  assign slotDone = (cntQ == curDiv);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divPriQ <= '0;
      divAltQ <= '0;
      patQ    <= '0;
      varQ    <= 1'b0;
    end else if (strb.load) begin
      divPriQ <= cfgClkDiv[DIV_W-1:0];
      divAltQ <= cfgClkDiv[2*DIV_W-1:DIV_W];
      patQ    <= cfgPattern;
      varQ    <= cfgVarEn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clear || strb.load) begin
      cntQ   <= '0;
      idxQ   <= '0;
      levelQ <= 1'b0;
    end else if (strb.advance) begin
      cntQ   <= '0;
      idxQ   <= (idxQ == LAST_SLOT) ? '0 : idxQ + 1'b1;
      levelQ <= !levelQ;
    end else if (strb.count) begin
      cntQ   <= cntQ + 1'b1;
    end
  end

  assign halfTick  = strb.advance;
  assign sclkLevel = levelQ;
  assign slotIdx   = idxQ;

endmodule

// File: rtl/spi_varclk_gen.sv
module spi_varclk_gen
  import spi_varclk_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int PAT_W      = 32,
  parameter bit ENABLE_VAR = 1'b1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      run,
  input  logic                      wordStart,
  input  logic                      cfgVarEn,
  input  logic [2*DIV_W-1:0]        cfgClkDiv,
  input  logic [PAT_W-1:0]          cfgPattern,
  output logic                      halfTick,
  output logic                      sclkLevel,
  output logic [$clog2(PAT_W)-1:0]  slotIdx
);

  vclkStrobes_t strb;
  logic         slotDone;

  spi_varclk_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .run       (run),
    .wordStart (wordStart),
    .slotDone  (slotDone),
    .strb      (strb)
  );

  spi_varclk_dp #(
    .DIV_W      (DIV_W),
    .PAT_W      (PAT_W),
    .ENABLE_VAR (ENABLE_VAR)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cfgVarEn   (cfgVarEn),
    .cfgClkDiv  (cfgClkDiv),
    .cfgPattern (cfgPattern),
    .slotDone   (slotDone),
    .halfTick   (halfTick),
    .sclkLevel  (sclkLevel),
    .slotIdx    (slotIdx)
  );

endmodule

// File: rtl/spi_varclk_chk.sv
module spi_varclk_chk #(
  parameter int PAT_W = 32,
  localparam int IDX_W = $clog2(PAT_W)
) (
  input logic             clk,
  input logic             rstN,
  input logic             run,
  input logic             wordStart,
  input logic             halfTick,
  input logic             sclkLevel,
  input logic [IDX_W-1:0] slotIdx
);

  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(PAT_W - 1);

  logic [IDX_W-1:0] nextIdx;
  assign nextIdx = (slotIdx == LAST_SLOT) ? '0 : slotIdx + 1'b1;

  // R2: idle state after run is low
  a_r2_idle_state: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (slotIdx == '0 && !sclkLevel));

  // R5: no tick during a restart cycle
  a_r5_no_tick_on_start: assert property (@(posedge clk) disable iff (!rstN)
    wordStart |-> !halfTick);

  // R5: restart state
  a_r5_restart_state: assert property (@(posedge clk) disable iff (!rstN)
    (run && wordStart) |=> (slotIdx == '0 && !sclkLevel));

  // R6: level inverts after a tick
  a_r6_level_toggle: assert property (@(posedge clk) disable iff (!rstN)
    halfTick |=> (sclkLevel != $past(sclkLevel)));

  // R6: level held between ticks
  a_r6_level_hold: assert property (@(posedge clk) disable iff (!rstN)
    (run && !wordStart && !halfTick) |=> $stable(sclkLevel));

  // R7: slot advances with wrap
  a_r7_slot_advance: assert property (@(posedge clk) disable iff (!rstN)
    halfTick |=> (slotIdx == $past(nextIdx)));

endmodule

bind spi_varclk_gen spi_varclk_chk #(.PAT_W(PAT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .run       (run),
  .wordStart (wordStart),
  .halfTick  (halfTick),
  .sclkLevel (sclkLevel),
  .slotIdx   (slotIdx)
);

// File: tb/spi_varclk_gen_tb.sv
module spi_varclk_gen_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        run = 1'b0;
  logic        wordStart = 1'b0;
  logic        cfgVarEn = 1'b0;
  logic [31:0] cfgClkDiv = '0;
  logic [31:0] cfgPattern = '0;
  logic        halfTick;
  logic        sclkLevel;
  logic [4:0]  slotIdx;

  always #2 clk = ~clk;  // 250 MHz

  spi_varclk_gen u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .run        (run),
    .wordStart  (wordStart),
    .cfgVarEn   (cfgVarEn),
    .cfgClkDiv  (cfgClkDiv),
    .cfgPattern (cfgPattern),
    .halfTick   (halfTick),
    .sclkLevel  (sclkLevel),
    .slotIdx    (slotIdx)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int t;
    int idx;
    bit lvl;
  } expTick_t;

  expTick_t expQ[$];
  string    curTag = "R1";
  int       nVec = 0;
  int       nBad = 0;
  bit       finished = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
  endtask

  // Monitor: compare every tick against the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rstN && halfTick) begin
        if (expQ.size() == 0) begin
          check(1'b0, curTag, "unexpected tick at cycle", cyc, -1);
        end else begin
          expTick_t e;
          e = expQ.pop_front();
          check(cyc == e.t, curTag, "tick cycle", cyc, e.t);
          check(int'(slotIdx) == e.idx, "R7", "slot index at tick", int'(slotIdx), e.idx);
          check(sclkLevel == e.lvl, "R6", "level at tick", int'(sclkLevel), int'(e.lvl));
        end
      end
    end
  end

  // Driver: start a word, predict its ticks, scramble config (R8).
  task automatic runWord(input logic [15:0] pri, input logic [15:0] alt,
                         input logic [31:0] pat, input bit ven,
                         input int nTicks, input bit keepRun, input string tag);
    int t;
    bit lvl;
    @(negedge clk);
    curTag     = tag;
    cfgClkDiv  = {alt, pri};
    cfgPattern = pat;
    cfgVarEn   = ven;
    run        = 1'b1;
    wordStart  = 1'b1;
    t   = cyc;
    lvl = 1'b0;
    for (int k = 0; k < nTicks; k++) begin
      int d;
      d = (ven && pat[k % 32]) ? int'(alt) : int'(pri);
      t = t + d + 1;
      expQ.push_back('{t, k % 32, lvl});
      lvl = !lvl;
    end
    @(negedge clk);
    wordStart  = 1'b0;
    cfgClkDiv  = ~{alt, pri};
    cfgPattern = ~pat;
    cfgVarEn   = !ven;
    while (cyc <= t) @(negedge clk);
    if (!keepRun) run = 1'b0;
    check(expQ.size() == 0, tag, "ticks still missing", expQ.size(), 0);
    expQ.delete();
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog expired: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(halfTick == 1'b0, "R1", "halfTick after reset", int'(halfTick), 0);
    check(sclkLevel == 1'b0, "R1", "sclkLevel after reset", int'(sclkLevel), 0);
    check(slotIdx == 5'd0, "R1", "slotIdx after reset", int'(slotIdx), 0);

    // R2: run high without a word start must stay quiet.
    @(negedge clk);
    curTag    = "R2";
    cfgClkDiv = 32'h0000_0000;
    run       = 1'b1;
    repeat (20) @(negedge clk);
    #1;
    check(slotIdx == 5'd0, "R2", "slotIdx with run and no start", int'(slotIdx), 0);
    check(sclkLevel == 1'b0, "R2", "level with run and no start", int'(sclkLevel), 0);
    run = 1'b0;

    // R3: fixed mode, pattern all ones must be ignored.
    runWord(16'd3, 16'd9, 32'hFFFF_FFFF, 1'b0, 6, 1'b0, "R3");
    // R9: field positions in fixed and variable mode.
    runWord(16'd1, 16'd6, 32'h0000_0000, 1'b0, 4, 1'b0, "R9");
    runWord(16'd1, 16'd6, 32'hFFFF_FFFF, 1'b1, 4, 1'b0, "R9");
    // R4: variable mode across a full 16-bit word.
    runWord(16'd2, 16'd5, 32'hA5C3_0F96, 1'b1, 32, 1'b0, "R4");
    // R7 and R10: wrap past slot 31 with a zero count.
    runWord(16'd0, 16'd1, 32'h0000_0003, 1'b1, 40, 1'b0, "R7");
    // R10: back-to-back ticks in fixed mode.
    runWord(16'd0, 16'd4, 32'h0000_0000, 1'b0, 8, 1'b0, "R10");

    // R2: idle after run drops.
    repeat (10) @(negedge clk);
    #1;
    check(slotIdx == 5'd0, "R2", "slotIdx while idle", int'(slotIdx), 0);
    check(sclkLevel == 1'b0, "R2", "level while idle", int'(sclkLevel), 0);

    // R5: restart in the middle of a word.
    runWord(16'd4, 16'd2, 32'h0000_0005, 1'b1, 5, 1'b1, "R5");
    runWord(16'd3, 16'd8, 32'h0000_00FF, 1'b0, 4, 1'b0, "R5");

    // R8: a word whose inputs change right after the start.
    runWord(16'd7, 16'd2, 32'h0000_00F0, 1'b1, 10, 1'b0, "R8");

    repeat (5) @(negedge clk);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule